// File: doc/BRIEF.md
# Half-Duplex Radio Mode Sequencer

This block paces an external half-duplex radio module through power-up, synthesizer channel loads, and turns between receive and transmit. It raises the module supply while both mode selects are low. It hands each channel word to a separate serial synthesizer writer through a one-cycle load strobe. It then counts millisecond ticks until the radio has settled, and only after that raises a data-path-ready flag. The wait after a load depends on history: it is long for the first load after reset and shorter for every later one. A turn between modes on an unchanged channel needs only a short wait.

The lock-detect line is looked at once, on a fixed tick after each load. Any activity on it before that tick has no effect. A failed lock raises an error flag. The radio then stays in receive mode, not ready, until the next channel load. Channel loads are accepted only in receive mode. Every transmission begins with a fixed-length preamble whose bit pattern depends on a bit-rate select. Every change of mode passes through one full tick with both selects low.

Top module: `radio_mode_seq`

## Requirements
- R1: Under reset, pwr_en, rx_on, tx_on, syn_load, data_ready, pre_active and lock_err are all 0. A start pulse raises pwr_en while rx_on and tx_on stay 0. rx_on rises on the first ms_tick after that.
- R2: A chan_req accepted in receive mode produces, on the next clock, a syn_load pulse of one cycle with syn_chan equal to the chan_in value presented alongside chan_req.
- R3: After the first channel load since reset, data_ready rises on the (FIRST_MS + RX_EXTRA_MS)-th ms_tick after the load, and not before.
- R4: After any later channel load, data_ready drops at once and rises again on the (LATER_MS + RX_EXTRA_MS)-th ms_tick after the load.
- R5: lock_det is sampled only on the LOCK_AT_MS-th tick after a load. If it is low then, lock_err goes to 1, data_ready stays 0 and rx_on stays 1 until the next accepted channel load, which clears lock_err. Values of lock_det on earlier ticks have no effect.
- R6: A chan_req while tx_on is 1 is refused. No syn_load pulse occurs, syn_chan keeps its value, and tx_on stays 1.
- R7: rx_on and tx_on are never 1 together. A mode change first drops both to 0, and the new select rises on the next ms_tick.
- R8: A tx_req while ready in receive mode drops data_ready. tx_on rises one tick later. pre_active rises SWITCH_MS ticks after tx_on and lasts PRE_MS ticks. data_ready then rises with tx_on still 1.
- R9: An rx_req in the transmit-ready state drops data_ready. rx_on rises one tick later, and data_ready rises SWITCH_MS + RX_EXTRA_MS ticks after rx_on, with no channel load.
- R10: During the preamble, pre_bit advances one bit per clock, starting with a 1. With slow_rate at 0 the pattern is 1,0,1,0,… and with slow_rate at 1 it is 1,1,0,0,….
- R11: tx_req is ignored unless the block is ready in receive mode. rx_req is ignored unless the block is ready in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins the power-up sequence |
| chan_req | input | 1 | Request to load a new channel |
| chan_in | input | CH_W | Channel word presented with chan_req |
| tx_req | input | 1 | Request to switch to transmit |
| rx_req | input | 1 | Request to switch back to receive |
| lock_det | input | 1 | Synthesizer lock-detect line |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| slow_rate | input | 1 | Selects the 4800 bps preamble pattern |
| pwr_en | output | 1 | Radio supply enable |
| rx_on | output | 1 | Receive mode select |
| tx_on | output | 1 | Transmit mode select |
| syn_load | output | 1 | Load strobe for the synthesizer writer |
| syn_chan | output | CH_W | Channel word for the synthesizer writer |
| data_ready | output | 1 | Data path may be used |
| pre_active | output | 1 | Preamble is being sent |
| pre_bit | output | 1 | Preamble bit stream |
| lock_err | output | 1 | Lock detect was low when sampled |

## Verification
The bench keeps the default 40, 20 and 5 ms settle counts, the 20 ms lock point and the 20 ms preamble. It sets RX_EXTRA_MS to 2, so the extra receive margin is added to every receive-side wait and can be told apart from the transmit-side switch wait. Ticks are spaced two clocks apart. This keeps the run short enough to cover both preamble patterns, lock failure and recovery, and a string of random channel loads with random lock glitches.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_PWR, ST_IDLE, ST_LOCK, ST_RX,
    ST_GAP_TX, ST_TXSET, ST_PRE, ST_TX, ST_GAP_RX, ST_RXSET
  } rms_state_t;
endpackage

// File: rtl/rms_tick_timer.sv
module rms_tick_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [TW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rms_preamble.sv
module rms_preamble #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic slow,
  output logic bit_o
);
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !active) ph <= '0;
    else ph <= ph + 1'b1;
  end

  // first preamble bit is 1; slow rate doubles each symbol
  assign bit_o = slow ? ~ph[1] : ~ph[0];

  assert_alt_R10: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !slow && $stable(slow)) |-> (bit_o != $past(bit_o)));
endmodule

// File: rtl/rms_ctrl.sv
module rms_ctrl
  import rms_pkg::*;
#(
  parameter int CH_W        = 8,
  parameter int TW          = 8,
  parameter int FIRST_MS    = 40,
  parameter int LATER_MS    = 20,
  parameter int SWITCH_MS   = 5,
  parameter int PRE_MS      = 20,
  parameter int LOCK_AT_MS  = 20,
  parameter int RX_EXTRA_MS = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            chan_req,
  input  logic [CH_W-1:0] chan_in,
  input  logic            tx_req,
  input  logic            rx_req,
  input  logic            lock_det,
  input  logic            ms_tick,
  input  logic [TW-1:0]   cnt,
  output logic            tmr_clr,
  output logic            pre_run,
  output logic            pwr_en,
  output logic            rx_on,
  output logic            tx_on,
  output logic            syn_load,
  output logic [CH_W-1:0] syn_chan,
  output logic            data_ready,
  output logic            pre_active,
  output logic            lock_err
);
  localparam logic [TW-1:0] LIM_FIRST = TW'(FIRST_MS + RX_EXTRA_MS - 1);
  localparam logic [TW-1:0] LIM_LATER = TW'(LATER_MS + RX_EXTRA_MS - 1);
  localparam logic [TW-1:0] LIM_LOCK  = TW'(LOCK_AT_MS - 1);
  localparam logic [TW-1:0] LIM_TXSW  = TW'(SWITCH_MS - 1);
  localparam logic [TW-1:0] LIM_RXSW  = TW'(SWITCH_MS + RX_EXTRA_MS - 1);
  localparam logic [TW-1:0] LIM_PRE   = TW'(PRE_MS - 1);

  rms_state_t st, st_n;
  logic first_pend, long_wait;
  logic load_ok, lock_fail;
  logic [TW-1:0] rdy_lim;

  assign rdy_lim   = long_wait ? LIM_FIRST : LIM_LATER;
  assign load_ok   = chan_req && (st == ST_IDLE || st == ST_RX || st == ST_LOCK);
  assign lock_fail = (st == ST_LOCK) && !load_ok && ms_tick && cnt == LIM_LOCK && !lock_det;

  always_comb begin
    st_n = st;
    case (st)
      ST_OFF:    if (start) st_n = ST_PWR;
      ST_PWR:    if (ms_tick) st_n = ST_IDLE;
      ST_IDLE:   if (load_ok) st_n = ST_LOCK;
      ST_LOCK: begin
        if (load_ok) st_n = ST_LOCK;
        else if (lock_fail) st_n = ST_IDLE;
        else if (ms_tick && cnt == rdy_lim) st_n = ST_RX;
      end
      ST_RX: begin
        if (load_ok) st_n = ST_LOCK;
        else if (tx_req) st_n = ST_GAP_TX;
      end
      ST_GAP_TX: if (ms_tick) st_n = ST_TXSET;
      ST_TXSET:  if (ms_tick && cnt == LIM_TXSW) st_n = ST_PRE;
      ST_PRE:    if (ms_tick && cnt == LIM_PRE) st_n = ST_TX;
      ST_TX:     if (rx_req) st_n = ST_GAP_RX;
      ST_GAP_RX: if (ms_tick) st_n = ST_RXSET;
      ST_RXSET:  if (ms_tick && cnt == LIM_RXSW) st_n = ST_RX;
      default:   st_n = ST_OFF;
    endcase
  end

  assign tmr_clr = (st_n != st) || load_ok;
  assign pre_run = (st == ST_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      first_pend <= 1'b1;
      long_wait  <= 1'b0;
      syn_load   <= 1'b0;
      syn_chan   <= '0;
      lock_err   <= 1'b0;
      pwr_en     <= 1'b0;
      rx_on      <= 1'b0;
      tx_on      <= 1'b0;
      data_ready <= 1'b0;
      pre_active <= 1'b0;
    end else begin
      st       <= st_n;
      syn_load <= load_ok;
      if (load_ok) begin
        syn_chan   <= chan_in;
        long_wait  <= first_pend;
        first_pend <= 1'b0;
        lock_err   <= 1'b0;
      end else if (lock_fail) begin
        lock_err <= 1'b1;
      end
      pwr_en     <= (st_n != ST_OFF);
      rx_on      <= st_n inside {ST_IDLE, ST_LOCK, ST_RX, ST_RXSET};
      tx_on      <= st_n inside {ST_TXSET, ST_PRE, ST_TX};
      data_ready <= st_n inside {ST_RX, ST_TX};
      pre_active <= (st_n == ST_PRE);
    end
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(rx_on && tx_on));
  assert_gap_tx_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_on) |-> $past(!rx_on));
  assert_gap_rx_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_on) |-> $past(!tx_on));
  assert_load_in_rx_R6: assert property (@(posedge clk) disable iff (rst)
    syn_load |-> (rx_on && !tx_on));
  assert_quiet_power_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> (!rx_on && !tx_on));
  assert_ready_no_err_R5: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> !lock_err);
  assert_pre_in_tx_R8: assert property (@(posedge clk) disable iff (rst)
    pre_active |-> (tx_on && !data_ready));
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq #(
  parameter int CH_W        = 8,
  parameter int FIRST_MS    = 40,
  parameter int LATER_MS    = 20,
  parameter int SWITCH_MS   = 5,
  parameter int PRE_MS      = 20,
  parameter int LOCK_AT_MS  = 20,
  parameter int RX_EXTRA_MS = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            chan_req,
  input  logic [CH_W-1:0] chan_in,
  input  logic            tx_req,
  input  logic            rx_req,
  input  logic            lock_det,
  input  logic            ms_tick,
  input  logic            slow_rate,
  output logic            pwr_en,
  output logic            rx_on,
  output logic            tx_on,
  output logic            syn_load,
  output logic [CH_W-1:0] syn_chan,
  output logic            data_ready,
  output logic            pre_active,
  output logic            pre_bit,
  output logic            lock_err
);
  localparam int MAX_WAIT = FIRST_MS + LATER_MS + SWITCH_MS + PRE_MS + RX_EXTRA_MS;
  localparam int TW       = $clog2(MAX_WAIT + 1) + 1;

  logic [TW-1:0] cnt;
  logic tmr_clr, pre_run;

  rms_tick_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(ms_tick), .cnt(cnt)
  );

  rms_ctrl #(
    .CH_W(CH_W), .TW(TW), .FIRST_MS(FIRST_MS), .LATER_MS(LATER_MS),
    .SWITCH_MS(SWITCH_MS), .PRE_MS(PRE_MS), .LOCK_AT_MS(LOCK_AT_MS),
    .RX_EXTRA_MS(RX_EXTRA_MS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .chan_req(chan_req), .chan_in(chan_in),
    .tx_req(tx_req), .rx_req(rx_req), .lock_det(lock_det), .ms_tick(ms_tick),
    .cnt(cnt), .tmr_clr(tmr_clr), .pre_run(pre_run), .pwr_en(pwr_en),
    .rx_on(rx_on), .tx_on(tx_on), .syn_load(syn_load), .syn_chan(syn_chan),
    .data_ready(data_ready), .pre_active(pre_active), .lock_err(lock_err)
  );

  rms_preamble #(.PH_W(2)) u_pre (
    .clk(clk), .rst(rst), .active(pre_run), .slow(slow_rate), .bit_o(pre_bit)
  );
endmodule

// File: tb/radio_mode_seq_bench.sv
module radio_mode_seq_bench;
  localparam int CH_W = 8, FIRST = 40, LATER = 20, SW = 5, PRE = 20, LOCKAT = 20, EXTRA = 2;

  logic clk = 0, rst = 1, start = 0, chan_req = 0, tx_req = 0, rx_req = 0;
  logic lock_det = 0, ms_tick = 0, slow_rate = 0;
  logic [CH_W-1:0] chan_in = '0;
  logic pwr_en, rx_on, tx_on, syn_load, data_ready, pre_active, pre_bit, lock_err;
  logic [CH_W-1:0] syn_chan;
  int checks = 0, errors = 0;
  logic [CH_W-1:0] last_chan;

  always #5 clk = ~clk;

  radio_mode_seq #(.CH_W(CH_W), .FIRST_MS(FIRST), .LATER_MS(LATER), .SWITCH_MS(SW),
    .PRE_MS(PRE), .LOCK_AT_MS(LOCKAT), .RX_EXTRA_MS(EXTRA)) u_radio_mode_seq (
    .clk(clk), .rst(rst), .start(start), .chan_req(chan_req), .chan_in(chan_in),
    .tx_req(tx_req), .rx_req(rx_req), .lock_det(lock_det), .ms_tick(ms_tick),
    .slow_rate(slow_rate), .pwr_en(pwr_en), .rx_on(rx_on), .tx_on(tx_on),
    .syn_load(syn_load), .syn_chan(syn_chan), .data_ready(data_ready),
    .pre_active(pre_active), .pre_bit(pre_bit), .lock_err(lock_err));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_pre(int k, bit slow);
    return slow ? (((k >> 1) % 2) == 0) : ((k % 2) == 0);
  endfunction

  task automatic tick();
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
  endtask

  task automatic load(logic [CH_W-1:0] v);
    @(negedge clk) begin chan_req = 1; chan_in = v; end
    @(negedge clk) chan_req = 0;
    chk("R2 syn_load", syn_load, 1);
    chk("R2 syn_chan", syn_chan, v);
    chk("R4 ready drops on load", data_ready, 0);
    chk("R5 err cleared by load", lock_err, 0);
    last_chan = v;
    @(negedge clk) chk("R2 strobe one cycle", syn_load, 0);
  endtask

  // wait n ticks after a load, glitching lock before the sample point
  task automatic settle(int n, bit good);
    for (int i = 1; i <= n; i++) begin
      lock_det = (i < LOCKAT) ? 1'($urandom) : (i == LOCKAT ? good : 1'($urandom));
      tick();
      if (!good && i == LOCKAT) begin
        chk("R5 err on bad lock", lock_err, 1);
        chk("R5 stays rx", rx_on, 1);
      end
      if (good && i == n - 1) chk("R3/R4 not yet ready", data_ready, 0);
      if (i == n) chk(good ? "R3/R4 ready" : "R5 never ready", data_ready, 32'(good));
      if (good && i < LOCKAT) chk("R5 glitch ignored", lock_err, 0);
    end
    lock_det = 1;
  endtask

  task automatic go_tx(bit slow);
    slow_rate = slow;
    @(negedge clk) tx_req = 1;
    @(negedge clk) tx_req = 0;
    chk("R7 gap rx", rx_on, 0); chk("R7 gap tx", tx_on, 0); chk("R8 ready drops", data_ready, 0);
    tick();
    chk("R7 tx after gap", tx_on, 1);
    for (int i = 1; i <= SW; i++) begin
      if (i == SW) chk("R8 no pre early", pre_active, 0);
      tick();
    end
    chk("R8 pre starts", pre_active, 1);
    for (int k = 0; k < 8; k++) begin
      chk(slow ? "R10 slow pattern" : "R10 alt pattern", pre_bit, 32'(exp_pre(k, slow)));
      if (k < 7) @(negedge clk);
    end
    for (int i = 1; i <= PRE; i++) begin
      tick();
      if (i == PRE - 1) chk("R8 pre still on", pre_active, 1);
    end
    chk("R8 pre ends", pre_active, 0);
    chk("R8 tx ready", data_ready, 1);
    chk("R8 tx held", tx_on, 1);
  endtask

  task automatic go_rx();
    @(negedge clk) rx_req = 1;
    @(negedge clk) rx_req = 0;
    chk("R7 gap tx off", tx_on, 0); chk("R7 gap rx off", rx_on, 0); chk("R9 ready drops", data_ready, 0);
    tick();
    chk("R7 rx after gap", rx_on, 1);
    for (int i = 1; i <= SW + EXTRA; i++) begin
      tick();
      if (i == SW + EXTRA - 1) chk("R9 not yet", data_ready, 0);
    end
    chk("R9 rx ready", data_ready, 1);
    chk("R9 no load", syn_load, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 pwr", pwr_en, 0); chk("R1 rx", rx_on, 0); chk("R1 tx", tx_on, 0);
    chk("R1 ready", data_ready, 0); chk("R1 err", lock_err, 0); chk("R1 load", syn_load, 0);
    rst = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R1 pwr on", pwr_en, 1); chk("R1 rx off", rx_on, 0); chk("R1 tx off", tx_on, 0);
    tick();
    chk("R1 rx on", rx_on, 1);
    // R11: transmit request before any channel is ready
    @(negedge clk) tx_req = 1;
    @(negedge clk) tx_req = 0;
    tick();
    chk("R11 tx_req ignored idle", tx_on, 0);
    load(8'h5A);
    settle(FIRST + EXTRA, 1);                 // R3
    load(8'h33);
    settle(LATER + EXTRA, 1);                 // R4
    // R11: rx_req in receive mode does nothing
    @(negedge clk) rx_req = 1;
    @(negedge clk) rx_req = 0;
    chk("R11 rx_req ignored", data_ready, 1); chk("R11 rx held", rx_on, 1);
    go_tx(0);
    // R6: refused load in transmit
    @(negedge clk) begin chan_req = 1; chan_in = 8'hC3; end
    @(negedge clk) chan_req = 0;
    chk("R6 no strobe", syn_load, 0);
    @(negedge clk) chk("R6 chan kept", syn_chan, last_chan);
    chk("R6 tx kept", tx_on, 1);
    go_rx();
    go_tx(1);
    go_rx();
    // R5: lock failure and recovery
    load(8'h81);
    settle(LATER + EXTRA, 0);
    @(negedge clk) tx_req = 1;
    @(negedge clk) tx_req = 0;
    tick();
    chk("R11 tx_req ignored after fail", tx_on, 0);
    chk("R5 err held", lock_err, 1);
    load(8'h82);
    settle(LATER + EXTRA, 1);
    // random channel loads with random lock outcomes
    for (int r = 0; r < 8; r++) begin
      bit good = 1'($urandom % 4 != 0);
      load(8'($urandom));
      settle(LATER + EXTRA, good);
      if (!good) begin load(8'($urandom)); settle(LATER + EXTRA, 1); end
      if ($urandom % 2) begin go_tx(1'($urandom)); go_rx(); end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule